// File: doc/BRIEF.md
# Low-Frequency Independent Watchdog with Early-Warning Compare

This block is a watchdog timer that runs from a slow, always-on clock. A free-running 12-bit divider sets the rate at which an 8-bit counter steps down. Software holds the counter away from zero by writing a fixed key to a refresh address. When the counter is at zero and the next step is due, the block reloads the counter. It then either raises a reset request that stays high until the next reset, or sets an interrupt flag. A configuration bit chooses between the two, and that bit can only be set.

Two separate compare units watch the counter. Each one flags an early warning when the counter steps onto its programmed value. While the system is in sleep or stop mode, any pending flag drives a wakeup output. Because underflow can interrupt instead of reset, the block can also serve as a periodic wakeup source.

The register port works in the slow clock domain. The three status flags are also carried into the bus clock domain through a two-flop synchronizer.

Top module: `lfwdt_top`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the reload register (address 1) and the counter (address 6) read 0xFF, the flag register (address 5) reads 0, and `irq_o`, `wake_o`, `rst_req_o` and `bus_flags_o` are all low.
- R2: Control bits [5:2] hold a divide select s. While the run bit (bit 0) is set, the counter steps once every 2^s slow-clock cycles, counted from the last refresh. Any s above 12 behaves as 12, so the longest period is 4096 cycles.
- R3: Writing exactly 0x5AC3 to address 4 loads the counter with the reload value and restarts the divider in that cycle. A write of any other value to address 4 leaves the counter unchanged.
- R4: In interrupt mode (control bit 1 clear), a step taken while the counter is 0 reloads the counter and sets flag bit 0. `irq_o` is high while any flag bit is set.
- R5: In reset mode (control bit 1 set), such a step raises `rst_req_o` instead of setting flag bit 0. `rst_req_o` then stays high until `rst_n` is asserted.
- R6: Control bit 1 can be set by a write but is not cleared by a later write of 0. Only reset clears it.
- R7: Compare unit i (i = 0, 1) has its threshold at address 2+i and its enable at control bit 6+i. When enabled, it sets flag bit 1+i in the cycle the counter steps down onto the threshold. A load of the counter by refresh or by underflow reload never sets the flag.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it as it is. If a new event arrives in the same cycle as a clear, the event wins.
- R9: `sleep_i` has no effect on counting. `wake_o` is high exactly when `sleep_i` is high and at least one flag bit is set.
- R10: `bus_flags_o` follows the three flag bits through two `bus_clk` flops.
- R11: While the run bit is clear, the counter and the divider hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lf | input | 1 | Slow, always-on clock for counting and the register port |
| bus_clk | input | 1 | Bus clock for the synchronized status flags |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Register write strobe, sampled on `clk_lf` |
| addr_i | input | 3 | Register address for both write and read |
| wdata_i | input | 16 | Write data |
| sleep_i | input | 1 | High while the system is in sleep or stop mode |
| rd_data_o | output | 16 | Combinational read data for `addr_i` |
| irq_o | output | 1 | High while any flag bit is set |
| wake_o | output | 1 | Wakeup request while asleep with a flag pending |
| rst_req_o | output | 1 | Latched reset request after an underflow in reset mode |
| bus_flags_o | output | 3 | Flag bits synchronized to `bus_clk` |

## Verification
A register write, a refresh, a counter step and a flag event all take effect on the same `clk_lf` edge that samples them. The counter, the flags, `irq_o` and `wake_o` therefore show the result on the falling edge that follows. `bus_flags_o` lags the flags by two `bus_clk` edges. The bench drives inputs shortly after each rising edge, updates a behavioural model on the rising edge, and compares the counter and all slow-domain outputs against it on every falling edge. It reads the synchronized flags only after several bus cycles have passed.

// File: rtl/lfwdt_pkg.sv
package lfwdt_pkg;

    // register map
    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_RELOAD = 3'd1,
        A_CMP0   = 3'd2,
        A_CMP1   = 3'd3,
        A_KICK   = 3'd4,
        A_FLAG   = 3'd5,
        A_COUNT  = 3'd6
    } reg_addr_e;

    localparam int NCMP   = 2;
    localparam int FLAG_W = NCMP + 1;
    localparam int SEL_W  = 4;

    // control register, run bit in bit 0
    typedef struct packed {
        logic [NCMP-1:0]  cmp_en;
        logic [SEL_W-1:0] div_sel;
        logic             rst_mode;
        logic             run;
    } ctrl_t;

endpackage

// File: rtl/lfwdt_prescaler.sv
module lfwdt_prescaler #(
    parameter int PRE_W = 12,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] div;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [SEL_W-1:0] sel_eff;
    logic [PRE_W:0]   one_sh;
    logic [PRE_W-1:0] mask;

    always_comb begin
        sel_eff = (sel_i > SEL_W'(PRE_W)) ? SEL_W'(PRE_W) : sel_i;
        one_sh  = ((PRE_W+1)'(1)) << sel_eff;
        mask    = PRE_W'(one_sh - (PRE_W+1)'(1));
        tick_o  = run_i & ((st_q.div & mask) == mask);
        st_d    = st_q;
        if (clear_i) begin
            st_d.div = '0;
        end else if (run_i) begin
            st_d.div = st_q.div + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a refresh restarts the divider
    a_r3_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.div == '0));

    // R11: divider holds while stopped
    a_r11_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clear_i) |=> $stable(st_q.div));

endmodule

// File: rtl/lfwdt_countdown.sv
module lfwdt_countdown #(
    parameter int CNT_W = 8,
    parameter int NCMP  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       kick_i,
    input  logic [CNT_W-1:0]           reload_i,
    input  logic [NCMP-1:0][CNT_W-1:0] cmp_val_i,
    input  logic [NCMP-1:0]            cmp_en_i,
    output logic [CNT_W-1:0]           cnt_o,
    output logic                       uflow_o,
    output logic [NCMP-1:0]            match_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic             step;
    logic [CNT_W-1:0] dec;

    always_comb begin
        step    = tick_i & ~kick_i;
        dec     = st_q.cnt - CNT_W'(1);
        uflow_o = step & (st_q.cnt == '0);
        st_d    = st_q;
        if (kick_i || uflow_o) begin
            st_d.cnt = reload_i;
        end else if (step) begin
            st_d.cnt = dec;
        end
    end

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        assign match_o[g] = step & (st_q.cnt != '0) & cmp_en_i[g] & (dec == cmp_val_i[g]);
    end

    assign cnt_o = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: refresh loads the reload value
    a_r3_kick_load: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (st_q.cnt == $past(reload_i)));

    // R4: underflow reloads the counter
    a_r4_uflow_reload: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_o |=> (st_q.cnt == $past(reload_i)));

    // R11: no step and no refresh means the count holds
    a_r11_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !kick_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/lfwdt_csr.sv
module lfwdt_csr
    import lfwdt_pkg::*;
#(
    parameter int          CNT_W  = 8,
    parameter int          DATA_W = 16,
    parameter logic [15:0] KEY    = 16'h5AC3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [2:0]                 addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic [CNT_W-1:0]           cnt_i,
    input  logic                       uflow_i,
    input  logic [NCMP-1:0]            match_i,
    output ctrl_t                      ctrl_o,
    output logic [CNT_W-1:0]           reload_o,
    output logic [NCMP-1:0][CNT_W-1:0] cmp_val_o,
    output logic                       kick_o,
    output logic [FLAG_W-1:0]          flags_o,
    output logic                       rst_req_o,
    output logic [DATA_W-1:0]          rd_data_o
);

    typedef struct packed {
        ctrl_t                      ctrl;
        logic [CNT_W-1:0]           reload;
        logic [NCMP-1:0][CNT_W-1:0] cmp;
        logic [FLAG_W-1:0]          flags;
        logic                       rst_req;
    } csr_st_t;

    csr_st_t           st_d, st_q;
    ctrl_t             ctrl_wr;
    logic [FLAG_W-1:0] clr, set;

    always_comb begin
        st_d    = st_q;
        ctrl_wr = ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
        kick_o  = wr_en_i && (addr_i == A_KICK) && (wdata_i == DATA_W'(KEY));
        clr     = (wr_en_i && (addr_i == A_FLAG)) ? wdata_i[FLAG_W-1:0] : '0;
        set     = {match_i, uflow_i & ~st_q.ctrl.rst_mode};

        if (wr_en_i) begin
            unique case (addr_i)
                A_CTRL: begin
                    st_d.ctrl          = ctrl_wr;
                    st_d.ctrl.rst_mode = st_q.ctrl.rst_mode | ctrl_wr.rst_mode;
                end
                A_RELOAD: st_d.reload = wdata_i[CNT_W-1:0];
                A_CMP0:   st_d.cmp[0] = wdata_i[CNT_W-1:0];
                A_CMP1:   st_d.cmp[1] = wdata_i[CNT_W-1:0];
                default:  ;
            endcase
        end

        st_d.flags   = (st_q.flags & ~clr) | set;
        st_d.rst_req = st_q.rst_req | (uflow_i & st_q.ctrl.rst_mode);

        unique case (addr_i)
            A_CTRL:   rd_data_o = DATA_W'(st_q.ctrl);
            A_RELOAD: rd_data_o = DATA_W'(st_q.reload);
            A_CMP0:   rd_data_o = DATA_W'(st_q.cmp[0]);
            A_CMP1:   rd_data_o = DATA_W'(st_q.cmp[1]);
            A_FLAG:   rd_data_o = DATA_W'(st_q.flags);
            A_COUNT:  rd_data_o = DATA_W'(cnt_i);
            default:  rd_data_o = '0;
        endcase
    end

    assign ctrl_o    = st_q.ctrl;
    assign reload_o  = st_q.reload;
    assign cmp_val_o = st_q.cmp;
    assign flags_o   = st_q.flags;
    assign rst_req_o = st_q.rst_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.reload <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: reset request holds until reset
    a_r5_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |=> st_q.rst_req);

    // R6: reset-mode bit cannot be cleared by writes
    a_r6_mode_lock: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.rst_mode |=> st_q.ctrl.rst_mode);

    // R4 and R8: underflow event sets its flag even when a clear arrives with it
    a_r4_uflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow_i && !st_q.ctrl.rst_mode) |=> st_q.flags[0]);

    // R7 and R8: compare events set their flags
    a_r7_cmp0_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_i[0] |=> st_q.flags[1]);

    a_r7_cmp1_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_i[1] |=> st_q.flags[2]);

endmodule

// File: rtl/lfwdt_sync.sv
module lfwdt_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/lfwdt_top.sv
module lfwdt_top
    import lfwdt_pkg::*;
#(
    parameter int          CNT_W  = 8,
    parameter int          PRE_W  = 12,
    parameter int          DATA_W = 16,
    parameter logic [15:0] KEY    = 16'h5AC3
) (
    input  logic              clk_lf,
    input  logic              bus_clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sleep_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic              wake_o,
    output logic              rst_req_o,
    output logic [FLAG_W-1:0] bus_flags_o
);

    ctrl_t                      ctrl;
    logic [CNT_W-1:0]           reload;
    logic [NCMP-1:0][CNT_W-1:0] cmp_val;
    logic                       kick, tick, uflow;
    logic [NCMP-1:0]            match;
    logic [CNT_W-1:0]           cnt;
    logic [FLAG_W-1:0]          flags;

    lfwdt_csr #(.CNT_W(CNT_W), .DATA_W(DATA_W), .KEY(KEY)) u_csr (
        .clk       (clk_lf),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .cnt_i     (cnt),
        .uflow_i   (uflow),
        .match_i   (match),
        .ctrl_o    (ctrl),
        .reload_o  (reload),
        .cmp_val_o (cmp_val),
        .kick_o    (kick),
        .flags_o   (flags),
        .rst_req_o (rst_req_o),
        .rd_data_o (rd_data_o)
    );

    lfwdt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk     (clk_lf),
        .rst_n   (rst_n),
        .run_i   (ctrl.run),
        .clear_i (kick),
        .sel_i   (ctrl.div_sel),
        .tick_o  (tick)
    );

    lfwdt_countdown #(.CNT_W(CNT_W), .NCMP(NCMP)) u_cnt (
        .clk       (clk_lf),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .kick_i    (kick),
        .reload_i  (reload),
        .cmp_val_i (cmp_val),
        .cmp_en_i  (ctrl.cmp_en),
        .cnt_o     (cnt),
        .uflow_o   (uflow),
        .match_o   (match)
    );

    lfwdt_sync #(.W(FLAG_W)) u_sync (
        .clk   (bus_clk),
        .rst_n (rst_n),
        .d_i   (flags),
        .q_o   (bus_flags_o)
    );

    assign irq_o  = |flags;
    assign wake_o = sleep_i & irq_o;

    // R9: wakeup only while asleep
    a_r9_wake_sleep: assert property (@(posedge clk_lf) disable iff (!rst_n)
        wake_o |-> sleep_i);

endmodule

// File: tb/lfwdt_top_tb_top.sv
module lfwdt_top_tb_top;

    localparam logic [15:0] KEY = 16'h5AC3;

    logic        clk = 1'b0;
    logic        bus_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd6;
    logic [15:0] wdata = '0;
    logic        sleep = 1'b0;
    logic [15:0] rd_data;
    logic        irq, wake, rst_req;
    logic [2:0]  bus_flags;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;
    always #7 bus_clk = ~bus_clk;

    lfwdt_top dut_i (
        .clk_lf      (clk),
        .bus_clk     (bus_clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .sleep_i     (sleep),
        .rd_data_o   (rd_data),
        .irq_o       (irq),
        .wake_o      (wake),
        .rst_req_o   (rst_req),
        .bus_flags_o (bus_flags)
    );

    // behavioural reference model
    int       m_cnt, m_reload, m_div, m_sel;
    int       m_cmp [2];
    bit       m_run, m_rmode, m_rst;
    bit [1:0] m_cen;
    bit [2:0] m_flags;

    always @(posedge clk or negedge rst_n) begin : model
        int       per;
        bit       kick, tick;
        bit [2:0] set, clr;
        if (!rst_n) begin
            m_cnt = 255; m_reload = 255; m_div = 0; m_sel = 0;
            m_cmp[0] = 0; m_cmp[1] = 0;
            m_run = 0; m_rmode = 0; m_rst = 0; m_cen = 0; m_flags = 0;
        end else begin
            per  = 1 << ((m_sel > 12) ? 12 : m_sel);
            kick = wr_en && addr == 3'd4 && wdata == KEY;
            tick = m_run && ((m_div % per) == per - 1);
            set  = 0;
            clr  = (wr_en && addr == 3'd5) ? wdata[2:0] : 3'b0;
            if (kick) begin
                m_cnt = m_reload;
                m_div = 0;
            end else begin
                if (tick) begin
                    if (m_cnt == 0) begin
                        m_cnt = m_reload;
                        if (m_rmode) m_rst = 1; else set[0] = 1;
                    end else begin
                        m_cnt = m_cnt - 1;
                        for (int i = 0; i < 2; i++)
                            if (m_cen[i] && m_cnt == m_cmp[i]) set[i+1] = 1;
                    end
                end
                if (m_run) m_div = (m_div + 1) % 4096;
            end
            if (wr_en) begin
                case (addr)
                    3'd0: begin
                        m_run   = wdata[0];
                        m_rmode = m_rmode | wdata[1];
                        m_sel   = int'(wdata[5:2]);
                        m_cen   = wdata[7:6];
                    end
                    3'd1: m_reload = int'(wdata[7:0]);
                    3'd2: m_cmp[0] = int'(wdata[7:0]);
                    3'd3: m_cmp[1] = int'(wdata[7:0]);
                    default: ;
                endcase
            end
            m_flags = (m_flags & ~clr) | set;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle compare against the model (R2 R4 R5 R7 R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (!wr_en && addr == 3'd6)
                chk("R2 R4 cycle count", int'(rd_data), m_cnt);
            chk("R4 R7 cycle irq", int'(irq), int'(m_flags != 0));
            chk("R5 cycle rst_req", int'(rst_req), int'(m_rst));
            chk("R9 cycle wake", int'(wake), int'(sleep && m_flags != 0));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk);
        #2;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #2;
        wr_en = 1'b0; addr = 3'd6; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a;
        #1;
        v = int'(rd_data);
        addr = 3'd6;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nfail);
        $finish;
    endtask

    initial begin
        #3_000_000;
        nfail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin : stim
        int v, c0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd1, v); chk("R1 reload", v, 255);
        rd(3'd6, v); chk("R1 count", v, 255);
        rd(3'd5, v); chk("R1 flags", v, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 rst_req", int'(rst_req), 0);
        chk("R1 bus_flags", int'(bus_flags), 0);

        // periodic run, divide by 2, both compares enabled
        wr(3'd1, 16'd5);
        wr(3'd2, 16'd3);
        wr(3'd3, 16'd1);
        wr(3'd0, 16'h00C5);
        wr(3'd4, KEY);
        idle(30);
        rd(3'd5, v); chk("R4 R7 all flags set", v, 7);
        chk("R4 irq high", int'(irq), 1);
        chk("R10 bus flags", int'(bus_flags), 7);
        sleep = 1'b1;
        idle(1);
        chk("R9 wake while asleep", int'(wake), 1);
        sleep = 1'b0;
        idle(1);
        chk("R9 no wake when awake", int'(wake), 0);

        // stop, then write-one-to-clear
        wr(3'd0, 16'h00C4);
        wr(3'd5, 16'd2);
        rd(3'd5, v); chk("R8 clear bit 1 only", v, 5);
        wr(3'd5, 16'd5);
        rd(3'd5, v); chk("R8 clear rest", v, 0);
        idle(5);
        chk("R10 bus flags cleared", int'(bus_flags), 0);

        // R11 frozen while stopped
        rd(3'd6, c0);
        idle(25);
        rd(3'd6, v); chk("R11 count held", v, c0);

        // R3 wrong key ignored, right key reloads
        wr(3'd4, 16'h1234);
        rd(3'd6, v); chk("R3 wrong key ignored", v, c0);
        wr(3'd4, KEY);
        rd(3'd6, v); chk("R3 key reloads", v, 5);

        // R7 a refresh load onto the threshold sets no flag
        wr(3'd2, 16'd5);
        wr(3'd0, 16'h0040);
        wr(3'd4, KEY);
        idle(2);
        rd(3'd5, v); chk("R7 no flag on refresh load", v, 0);

        // R2 clamp: select 15 acts as 4096 cycles
        wr(3'd0, 16'h003D);
        wr(3'd4, KEY);
        idle(4090);
        rd(3'd6, v); chk("R2 no step before 4096", v, 5);
        idle(10);
        rd(3'd6, v); chk("R2 one step at 4096", v, 4);

        // R9 counting continues while asleep, divide by 1
        sleep = 1'b1;
        wr(3'd0, 16'h0001);
        wr(3'd4, KEY);
        idle(3);
        rd(3'd6, v); chk("R9 counts while asleep", v, 2);
        chk("R9 no wake without flag", int'(wake), 0);
        idle(5);
        chk("R4 underflow irq", int'(irq), 1);
        chk("R9 wake on flag", int'(wake), 1);
        sleep = 1'b0;

        // R5 R6 reset mode
        wr(3'd0, 16'h0000);
        wr(3'd5, 16'd7);
        wr(3'd0, 16'h0002);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R6 mode bit locked", v, 2);
        wr(3'd4, KEY);
        wr(3'd0, 16'h0003);
        idle(10);
        chk("R5 reset request", int'(rst_req), 1);
        rd(3'd5, v); chk("R5 no underflow flag", v, 0);
        idle(8);
        chk("R5 request held", int'(rst_req), 1);

        @(posedge clk);
        #2;
        rst_n = 1'b0;
        #20;
        rst_n = 1'b1;
        idle(1);
        chk("R5 cleared by reset", int'(rst_req), 0);
        rd(3'd0, v); chk("R6 cleared by reset", v, 0);

        summary();
    end

endmodule